// File: doc/BRIEF.md
# OUT Endpoint Transfer-Stop Sequencer

This block is a small bus master that runs the complete stop procedure for every OUT endpoint of a USB device controller, typically after the host has signalled a bus reset, with no processor involvement. A single start pulse launches the procedure. The sequencer then issues reads, writes and read-modify-writes on a simple request/acknowledge register bus towards the controller core. It reports progress on `busy_o` and ends with a one-cycle `done_o` pulse that carries a pass or fail result on `fail_o`.

First, every OUT endpoint is re-enabled. The sequencer then waits for the core's bus master to go idle, flushes the receive FIFO, and polls for flush completion under a programmable cycle-count limit. That limit stands in for the roughly 10 ms reset window, and a flush that does not complete in time is started once more. After the flush, the sequencer raises global OUT NAK, waits for it to take effect, and disables the endpoints one at a time, waiting for each one to confirm. Every interrupt status bit it has observed is cleared by writing 1 to it. The number of endpoints is a parameter.

Top module: `out_stop_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o` and `req_o` are all 0.
- R2: A start pulse in idle first writes 0x8000_0000 (enable, bit 31) to the control register of each endpoint 0 to N-1 in ascending order. The control register of endpoint e sits at 0x300 + 0x20*e.
- R3: The sequencer then reads the core-control register at 0x010 repeatedly and writes nothing to it until a read returns bit 31 (bus-master idle) set.
- R4: The flush is a read of 0x010 followed by a write to 0x010 of the value read with bit 4 (receive-FIFO flush) set. All other bits are preserved.
- R5: After the flush write, 0x010 is polled until bit 4 reads 0. If a poll still sees bit 4 set once at least `tmo_limit_i` cycles have passed since the flush write, the read-modify-write flush is repeated exactly once.
- R6: If the repeated flush also times out, the sequence ends with `fail_o`=1 and no write is made to the device-control register.
- R7: After a successful flush, the sequencer writes 0x200 (set global OUT NAK, bit 9) to device-control at 0x080. It then polls the global interrupt status at 0x014 until bit 7 is set, and clears that bit by writing 0x80 to 0x014.
- R8: For each endpoint e in ascending order, the sequencer writes 0x4800_0000 (disable bit 30, set-NAK bit 27) to its control register. It then polls the endpoint interrupt register at 0x308 + 0x20*e until bit 1 (disabled) is set, and writes 0x2 there before moving to the next endpoint.
- R9: A wait on the global NAK bit or an endpoint disabled bit that lasts `tmo_limit_i` cycles or more ends the sequence with `fail_o`=1, and no later step is issued.
- R10: `busy_o` is 1 from the cycle after start until the end. The end is marked by a one-cycle `done_o` pulse, with `busy_o` low, and `fail_o`=0 on success. `fail_o` changes only together with `done_o`.
- R11: A start pulse while `busy_o` is 1 has no effect.
- R12: Once raised, `req_o` stays high, with `we_o`, `addr_o` and `wdata_o` stable, until the cycle in which `ack_i` is 1. `rdata_i` is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| tmo_limit_i | input | TW | Timeout limit in clock cycles |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Result of last sequence, 1 = failed |
| req_o | output | 1 | Bus request |
| we_o | output | 1 | Bus write enable |
| addr_o | output | AW | Bus byte address |
| wdata_o | output | 32 | Bus write data |
| rdata_i | input | 32 | Bus read data, valid with ack |
| ack_i | input | 1 | Bus acknowledge |

## Verification
On every cycle, the assertions check the bus hold rule, and that a request appears only while busy. They also check that busy can rise only after a start pulse, that done is a single-cycle pulse never seen with busy, and that the result flag moves only with done. The order and contents of the register accesses, the preservation of bits in the flush read-modify-write, the single flush retry, and the fail exits of each timed wait depend on how the core answers. Only the bench's scenarios, which drive a register model with chosen latencies, can show these.

// File: rtl/out_stop_pkg.sv
package out_stop_pkg;
  localparam int DW = 32;

  // register byte addresses
  localparam int CORE_CTL_ADR = 'h010;
  localparam int GINT_ADR     = 'h014;
  localparam int DEV_CTL_ADR  = 'h080;
  localparam int EP_CTL_BASE  = 'h300;
  localparam int EP_INT_BASE  = 'h308;
  localparam int EP_STRIDE    = 'h20;

  // bit positions the core decodes
  localparam int IDLE_BIT  = 31;
  localparam int FLUSH_BIT = 4;
  localparam int GNAK_BIT  = 9;
  localparam int GNE_BIT   = 7;
  localparam int ENA_BIT   = 31;
  localparam int DIS_BIT   = 30;
  localparam int SNAK_BIT  = 27;
  localparam int EPD_BIT   = 1;

  localparam logic [DW-1:0] ENA_MSK   = DW'(1) << ENA_BIT;
  localparam logic [DW-1:0] DIS_MSK   = (DW'(1) << DIS_BIT) | (DW'(1) << SNAK_BIT);
  localparam logic [DW-1:0] FLUSH_MSK = DW'(1) << FLUSH_BIT;
  localparam logic [DW-1:0] GNAK_MSK  = DW'(1) << GNAK_BIT;
  localparam logic [DW-1:0] GNE_MSK   = DW'(1) << GNE_BIT;
  localparam logic [DW-1:0] EPD_MSK   = DW'(1) << EPD_BIT;

  typedef enum logic [3:0] {
    S_IDLE, S_ENA_WR, S_IDLE_RD, S_FL_RD, S_FL_WR, S_FL_POLL,
    S_GN_WR, S_GN_RD, S_GN_CLR, S_DIS_WR, S_DIS_RD, S_DIS_CLR
  } seq_st_e;
endpackage

// File: rtl/out_stop_tmr.sv
module out_stop_tmr #(
  parameter int TW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + TW'(1);
  end

  assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/out_stop_epc.sv
module out_stop_epc #(
  parameter int EP_N = 4,
  localparam int EW = (EP_N > 1) ? $clog2(EP_N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [EW-1:0] idx_o,
  output logic          last_o
);
  localparam logic [EW-1:0] LAST_IDX = EW'(EP_N - 1);

  generate
    if (EP_N == 1) begin : g_single
      assign idx_o  = '0;
      assign last_o = 1'b1;
    end else begin : g_multi
      logic [EW-1:0] idx_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       idx_q <= '0;
        else if (clr_i)                    idx_q <= '0;
        else if (inc_i && idx_q != LAST_IDX) idx_q <= idx_q + EW'(1);
      end
      assign idx_o  = idx_q;
      assign last_o = (idx_q == LAST_IDX);
    end
  endgenerate
endmodule

// File: rtl/out_stop_seq.sv
module out_stop_seq
  import out_stop_pkg::*;
#(
  parameter int EP_N = 4,
  parameter int AW   = 12,
  parameter int TW   = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] tmo_limit_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  input  logic          ack_i
);
  localparam int EW = (EP_N > 1) ? $clog2(EP_N) : 1;

  seq_st_e       state_q, state_d;
  logic          retry_q;
  logic [DW-1:0] rmw_q;
  logic          done_q, fail_q;

  logic          fin, fin_fail, retry_set, rmw_ld;
  logic          tmr_clr, tmr_exp;
  logic          ep_clr, ep_inc, ep_last;
  logic [EW-1:0] ep_idx;
  logic [AW-1:0] ep_off, ctl_adr, int_adr;

  out_stop_tmr #(.TW(TW)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .limit_i  (tmo_limit_i),
    .expired_o(tmr_exp)
  );

  out_stop_epc #(.EP_N(EP_N)) u_epc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ep_clr),
    .inc_i (ep_inc),
    .idx_o (ep_idx),
    .last_o(ep_last)
  );

  assign ep_off  = AW'(ep_idx) * AW'(EP_STRIDE);
  assign ctl_adr = AW'(EP_CTL_BASE) + ep_off;
  assign int_adr = AW'(EP_INT_BASE) + ep_off;

  always_comb begin
    state_d   = state_q;
    fin       = 1'b0;
    fin_fail  = 1'b0;
    retry_set = 1'b0;
    rmw_ld    = 1'b0;
    tmr_clr   = 1'b0;
    ep_clr    = 1'b0;
    ep_inc    = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_ENA_WR;
        ep_clr  = 1'b1;
      end
      S_ENA_WR: if (ack_i) begin
        if (ep_last) state_d = S_IDLE_RD;
        else         ep_inc  = 1'b1;
      end
      S_IDLE_RD: if (ack_i && rdata_i[IDLE_BIT]) state_d = S_FL_RD;
      S_FL_RD: if (ack_i) begin
        rmw_ld  = 1'b1;
        state_d = S_FL_WR;
      end
      S_FL_WR: if (ack_i) begin
        tmr_clr = 1'b1;
        state_d = S_FL_POLL;
      end
      S_FL_POLL: if (ack_i) begin
        if (!rdata_i[FLUSH_BIT]) state_d = S_GN_WR;
        else if (tmr_exp) begin
          if (retry_q) begin
            fin      = 1'b1;
            fin_fail = 1'b1;
          end else begin
            retry_set = 1'b1;
            state_d   = S_FL_RD;
          end
        end
      end
      S_GN_WR: if (ack_i) begin
        tmr_clr = 1'b1;
        state_d = S_GN_RD;
      end
      S_GN_RD: if (ack_i) begin
        if (rdata_i[GNE_BIT]) state_d = S_GN_CLR;
        else if (tmr_exp) begin
          fin      = 1'b1;
          fin_fail = 1'b1;
        end
      end
      S_GN_CLR: if (ack_i) begin
        ep_clr  = 1'b1;
        state_d = S_DIS_WR;
      end
      S_DIS_WR: if (ack_i) begin
        tmr_clr = 1'b1;
        state_d = S_DIS_RD;
      end
      S_DIS_RD: if (ack_i) begin
        if (rdata_i[EPD_BIT]) state_d = S_DIS_CLR;
        else if (tmr_exp) begin
          fin      = 1'b1;
          fin_fail = 1'b1;
        end
      end
      S_DIS_CLR: if (ack_i) begin
        if (ep_last) fin = 1'b1;
        else begin
          ep_inc  = 1'b1;
          state_d = S_DIS_WR;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      retry_q <= 1'b0;
      rmw_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (fin) fail_q <= fin_fail;
      if (state_q == S_IDLE && start_i) retry_q <= 1'b0;
      else if (retry_set)               retry_q <= 1'b1;
      if (rmw_ld) rmw_q <= rdata_i;
    end
  end

  // bus command decode, held by state until ack
  always_comb begin
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_q)
      S_ENA_WR: begin
        we_o = 1'b1; addr_o = ctl_adr; wdata_o = ENA_MSK;
      end
      S_IDLE_RD, S_FL_RD, S_FL_POLL: addr_o = AW'(CORE_CTL_ADR);
      S_FL_WR: begin
        we_o = 1'b1; addr_o = AW'(CORE_CTL_ADR); wdata_o = rmw_q | FLUSH_MSK;
      end
      S_GN_WR: begin
        we_o = 1'b1; addr_o = AW'(DEV_CTL_ADR); wdata_o = GNAK_MSK;
      end
      S_GN_RD: addr_o = AW'(GINT_ADR);
      S_GN_CLR: begin
        we_o = 1'b1; addr_o = AW'(GINT_ADR); wdata_o = GNE_MSK;
      end
      S_DIS_WR: begin
        we_o = 1'b1; addr_o = ctl_adr; wdata_o = DIS_MSK;
      end
      S_DIS_RD: addr_o = int_adr;
      S_DIS_CLR: begin
        we_o = 1'b1; addr_o = int_adr; wdata_o = EPD_MSK;
      end
      default: ;
    endcase
  end

  assign req_o  = (state_q != S_IDLE);
  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/out_stop_seq_chk.sv
module out_stop_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic          req_o,
  input logic          we_o,
  input logic [AW-1:0] addr_o,
  input logic [31:0]   wdata_o,
  input logic          ack_i
);
  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(we_o) && $stable(addr_o) && $stable(wdata_o)));

  // R12
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o);

  // R11
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R10
  fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fail_o) |-> done_o);
endmodule

bind out_stop_seq out_stop_seq_chk #(.AW(AW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .fail_o (fail_o),
  .req_o  (req_o),
  .we_o   (we_o),
  .addr_o (addr_o),
  .wdata_o(wdata_o),
  .ack_i  (ack_i)
);

// File: tb/out_stop_seq_tb.sv
`timescale 1ns/1ps
module out_stop_seq_tb;
  localparam int N  = 4;
  localparam int AW = 12;
  localparam int TW = 20;
  localparam int NEVER = 1000000;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic [TW-1:0] limit = 40;
  logic          busy, done, fail, req, we, ack;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;

  always #10 clk = ~clk;

  out_stop_seq #(.EP_N(N), .AW(AW), .TW(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tmo_limit_i(limit),
    .busy_o(busy), .done_o(done), .fail_o(fail),
    .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata),
    .rdata_i(rdata), .ack_i(ack)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // ---------------- register model of the core ----------------
  int  idle_dly, fl_lat0, fl_lat1, gn_lat;
  int  ep_lat[N];
  logic model_clr = 0;

  logic        hold;
  logic [31:0] rst_store;
  logic        fl_bit, gn_set, gne_bit, rst_wr_early;
  int          idle_rd, fl_rd, fl_att, gn_rd;
  logic        dis_set[N], epd_bit[N];
  int          ep_rd[N];
  logic [AW-1:0] wa[64];
  logic [31:0]   wd[64];
  int          nwr;

  logic idle_now;
  assign idle_now = (idle_rd >= idle_dly);
  assign ack = req && hold;

  function automatic int ep_ctl(logic [AW-1:0] a);
    for (int e = 0; e < N; e++) if (a == AW'('h300 + 'h20*e)) return e;
    return -1;
  endfunction
  function automatic int ep_int(logic [AW-1:0] a);
    for (int e = 0; e < N; e++) if (a == AW'('h308 + 'h20*e)) return e;
    return -1;
  endfunction

  always_comb begin
    rdata = '0;
    if (addr == AW'('h010)) rdata = rst_store | {idle_now, 26'd0, fl_bit, 4'd0};
    else if (addr == AW'('h014)) rdata = {24'd0, gne_bit, 7'd0};
    else if (ep_int(addr) >= 0) rdata = {30'd0, epd_bit[ep_int(addr)], 1'b0};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= req && !ack;
  end

  always @(posedge clk) begin
    if (model_clr) begin
      rst_store <= 32'h0000_0A00; fl_bit <= 0; gn_set <= 0; gne_bit <= 0;
      rst_wr_early <= 0; idle_rd <= 0; fl_rd <= 0; fl_att <= 0; gn_rd <= 0; nwr <= 0;
      for (int e = 0; e < N; e++) begin
        dis_set[e] <= 0; epd_bit[e] <= 0; ep_rd[e] <= 0;
      end
    end else if (req && ack) begin
      if (we) begin
        if (nwr < 64) begin wa[nwr] <= addr; wd[nwr] <= wdata; end
        nwr <= nwr + 1;
        if (addr == AW'('h010)) begin
          if (!idle_now) rst_wr_early <= 1;
          rst_store <= wdata & ~32'h8000_0010;
          if (wdata[4]) begin fl_bit <= 1; fl_rd <= 0; fl_att <= fl_att + 1; end
        end else if (addr == AW'('h080)) begin
          if (wdata[9]) gn_set <= 1;
        end else if (addr == AW'('h014)) begin
          if (wdata[7]) gne_bit <= 0;
        end else if (ep_ctl(addr) >= 0) begin
          if (wdata[30]) dis_set[ep_ctl(addr)] <= 1;
        end else if (ep_int(addr) >= 0) begin
          if (wdata[1]) epd_bit[ep_int(addr)] <= 0;
        end
      end else begin
        if (addr == AW'('h010)) begin
          idle_rd <= idle_rd + 1;
          if (fl_bit) begin
            fl_rd <= fl_rd + 1;
            if (fl_rd + 1 >= ((fl_att <= 1) ? fl_lat0 : fl_lat1)) fl_bit <= 0;
          end
        end else if (addr == AW'('h014)) begin
          if (gn_set) begin
            gn_rd <= gn_rd + 1;
            if (gn_rd + 1 >= gn_lat) gne_bit <= 1;
          end
        end else if (ep_int(addr) >= 0) begin
          if (dis_set[ep_int(addr)]) begin
            ep_rd[ep_int(addr)] <= ep_rd[ep_int(addr)] + 1;
            if (ep_rd[ep_int(addr)] + 1 >= ep_lat[ep_int(addr)]) epd_bit[ep_int(addr)] <= 1;
          end
        end
      end
    end
  end

  // ---------------- monitors ----------------
  int   done_cnt = 0, done_wide = 0, hold_err = 0;
  logic last_fail, p_done = 0, p_req = 0, p_ack = 0, p_we = 0;
  logic [AW-1:0] p_addr;
  logic [31:0]   p_wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin done_cnt++; last_fail = fail; end
      if (done && p_done) done_wide++;
      if (p_req && !p_ack && (!req || we != p_we || addr != p_addr || wdata != p_wdata))
        hold_err++;
    end
    p_done = done; p_req = req; p_ack = ack; p_we = we; p_addr = addr; p_wdata = wdata;
  end

  // ---------------- helpers ----------------
  task automatic cfg(int idl, int f0, int f1, int g, int e0, int e1, int e2, int e3);
    idle_dly = idl; fl_lat0 = f0; fl_lat1 = f1; gn_lat = g;
    ep_lat[0] = e0; ep_lat[1] = e1; ep_lat[2] = e2; ep_lat[3] = e3;
    @(negedge clk); model_clr = 1;
    @(negedge clk); model_clr = 0;
  endtask

  task automatic run(int restart_at);
    int d0 = done_cnt;
    start = 1; @(negedge clk); start = 0;
    chk("R10 busy after start", 32'(busy), 32'd1);
    for (int i = 0; i < 20000 && done_cnt == d0; i++) begin
      if (i == restart_at) start = 1;
      @(negedge clk);
      start = 0;
    end
    chk("R10 done seen", 32'(done_cnt - d0), 32'd1);
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_wr(int i, int a, logic [31:0] d, string r);
    chk(r, 32'(wa[i]), 32'(a));
    chk(r, wd[i], d);
  endtask

  task automatic chk_front(string r2);
    for (int e = 0; e < N; e++) chk_wr(e, 'h300 + 'h20*e, 32'h8000_0000, r2);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 fail", 32'(fail), 0);
    chk("R1 req", 32'(req), 0);
  endtask

  task automatic t_pass;
    cfg(3, 2, 2, 3, 0, 3, 1, 5);
    run(-1);
    chk("R10 pass flag", 32'(last_fail), 0);
    chk("R8 write count", 32'(nwr), 15);
    chk_front("R2 enable writes");
    chk("R3 no early flush write", 32'(rst_wr_early), 0);
    chk_wr(4, 'h010, 32'h8000_0A10, "R4 flush rmw");
    chk_wr(5, 'h080, 32'h0000_0200, "R7 set gnak");
    chk_wr(6, 'h014, 32'h0000_0080, "R7 clear gnak int");
    for (int e = 0; e < N; e++) begin
      chk_wr(7 + 2*e, 'h300 + 'h20*e, 32'h4800_0000, "R8 disable");
      chk_wr(8 + 2*e, 'h308 + 'h20*e, 32'h0000_0002, "R8 clear disabled int");
    end
    chk("R10 done width", 32'(done_wide), 0);
    chk("R12 bus hold", 32'(hold_err), 0);
    chk("R10 idle after done", 32'(busy), 0);
  endtask

  task automatic t_retry;
    cfg(0, NEVER, 2, 1, 1, 1, 1, 1);
    run(-1);
    chk("R5 retry pass flag", 32'(last_fail), 0);
    chk("R5 write count", 32'(nwr), 16);
    chk_wr(4, 'h010, 32'h8000_0A10, "R5 first flush");
    chk_wr(5, 'h010, 32'h8000_0A10, "R5 second flush");
    chk_wr(6, 'h080, 32'h0000_0200, "R5 moves to gnak");
  endtask

  task automatic t_flush_fail;
    cfg(1, NEVER, NEVER, 1, 1, 1, 1, 1);
    run(-1);
    chk("R6 fail flag", 32'(last_fail), 1);
    chk("R6 write count", 32'(nwr), 6);
    chk_wr(5, 'h010, 32'h8000_0A10, "R6 single retry");
    chk("R6 no devctl write", 32'(wa[nwr-1] == AW'('h080)), 0);
  endtask

  task automatic t_gnak_fail;
    cfg(0, 1, 1, NEVER, 1, 1, 1, 1);
    run(-1);
    chk("R9 gnak fail flag", 32'(last_fail), 1);
    chk("R9 gnak write count", 32'(nwr), 6);
    chk_wr(5, 'h080, 32'h0000_0200, "R9 last write is gnak set");
  endtask

  task automatic t_ep_fail;
    cfg(0, 1, 1, 1, 1, 2, NEVER, 1);
    run(-1);
    chk("R9 ep fail flag", 32'(last_fail), 1);
    chk("R9 ep write count", 32'(nwr), 12);
    chk_wr(11, 'h340, 32'h4800_0000, "R9 stops at endpoint 2");
  endtask

  task automatic t_restart;
    int d0;
    cfg(2, 3, 3, 2, 2, 2, 2, 2);
    run(10);
    d0 = done_cnt;
    repeat (300) @(negedge clk);
    chk("R11 no second run", 32'(done_cnt - d0), 0);
    chk("R11 write count", 32'(nwr), 15);
    chk("R11 pass flag", 32'(last_fail), 0);
  endtask

  initial begin
    cfg(0, 1, 1, 1, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_pass;
    t_retry;
    t_flush_fail;
    t_gnak_fail;
    t_ep_fail;
    t_restart;
    t_pass;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule